// File: doc/BRIEF.md
# Adaptive Dual-Protocol Host Register Port

This block is the host-side register port of a tone transceiver. A small microcontroller reaches it over a 4-bit data bus using a chip select, one register-select line and two strobe pins. The strobe pins are interpreted either as a data strobe plus read/write line or as separate active-low read and write strobes. The block chooses the interpretation anew at every falling edge of chip select, from the level of the first strobe pin at that moment. All pins are sampled by the system clock, so every bus event is seen one clock after the pin moves.

Behind the port sit a write-only transmit code register, a read-only receive code register, two control registers sharing one address, and a status register whose event flags clear when a status read finishes. The second control register is reached through a one-shot redirect bit in the first. An active-low open-drain interrupt pin, modelled as a "pull low" enable, reports received digits and transmitter readiness. In call-progress mode it instead shows an external comparator square wave, and in test mode it shows the delayed steering level.

Top module: `dtx_host_port`

## Requirements
- R1: At each falling edge of cs_n the first strobe pin is sampled: low selects the strobe/direction protocol (strobe_a high = access strobe, strobe_b 1 = read, 0 = write); high selects the split-strobe protocol (strobe_a low = read, strobe_b low = write). The choice holds until the next falling edge, so with cs_n low and strobes idle nothing is accessed in either protocol.
- R2: reg_sel 0 writes the transmit code and reads the receive code; reg_sel 1 writes the control address and reads the status register.
- R3: A control write lands in control A unless bit 3 of control A is set; then it lands in control B and clears control A bit 3, so the following control write lands in control A again.
- R4: A write takes effect when its write strobe ends, with the data held during the strobe; a transmit write updates tx_data and pulses tx_load for exactly one clock.
- R5: dq_oe is high only while a read access is active; it stays low with cs_n high and during write accesses.
- R6: Status bit 2 (receive full) sets and the receive code register loads rx_code on rx_valid, but only when control A bit 1 (call-progress mode) is 0; status bit 3 follows dsteer.
- R7: Status bit 1 (transmit empty) sets on tx_ready while control B bit 0 is 0 (burst enabled); it is held clear while control B bit 0 is 1.
- R8: Status bit 0 sets when bit 1 or bit 2 is set by an event while control A bit 2 (interrupt enable) is 1, and not otherwise.
- R9: Status bits 0 to 2 that were set when a status read began clear when that read ends; a flag set during the read survives it.
- R10: With interrupts enabled and call-progress mode off, irq_pull equals status bit 0.
- R11: With call-progress mode and interrupts enabled, irq_pull is the inverse of cp_cmp; with control B bit 1 (test) set in DTMF mode, irq_pull is the inverse of status bit 3.
- R12: Synchronous reset clears both control registers, the control B redirect, the status flags and the bus outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| strobe_a | input | 1 | Data strobe (high active) or read strobe (low active) |
| strobe_b | input | 1 | Read/write direction or write strobe (low active) |
| reg_sel | input | 1 | Register select |
| dq_in | input | 4 | Data bus, host to block |
| dq_out | output | 4 | Data bus, block to host |
| dq_oe | output | 1 | Data bus drive enable |
| rx_code | input | 4 | Code of a registered received digit |
| rx_valid | input | 1 | One-clock pulse: digit registered |
| dsteer | input | 1 | Delayed steering level |
| tx_ready | input | 1 | One-clock pulse: burst and pause finished |
| cp_cmp | input | 1 | Call-progress comparator output |
| ctrl_a | output | 4 | Control register A |
| ctrl_b | output | 4 | Control register B |
| tx_data | output | 4 | Transmit code register |
| tx_load | output | 1 | One-clock pulse on a transmit write |
| irq_pull | output | 1 | 1 pulls the open-drain interrupt pin low |

## Verification
The assertions watch on every cycle that the bus is never driven shortly after chip select has been high, that a redirected control write reaches control B and drops the redirect, that tx_load is a single-clock pulse, that transmit-empty stays clear with burst off, that the interrupt flag only rises when enabled, that read-clear drops a flag seen at read start, and that the pin tracks the comparator in call-progress mode. Protocol detection from real strobe sequences in both styles, the control-write ordering, the survival of a flag set mid-read and the priority among the pin's modes can only be shown by the bench's bus scenarios.

// File: rtl/dtx_host_pkg.sv
package dtx_host_pkg;
  localparam int DW = 4;
  // control A field positions
  localparam int CA_CP    = 1;
  localparam int CA_IRQ   = 2;
  localparam int CA_REDIR = 3;
  // control B field positions
  localparam int CB_NOBURST = 0;
  localparam int CB_TEST    = 1;
  // status field positions
  localparam int ST_IRQ  = 0;
  localparam int ST_TXE  = 1;
  localparam int ST_RXF  = 2;
  localparam int ST_DSTR = 3;
  localparam int ST_EVT  = 3;  // number of read-clear flags

  typedef enum logic {BUS_SPLIT_NO = 1'b0, BUS_SPLIT = 1'b1} bus_kind_e;
endpackage

// File: rtl/dtx_bus_sense.sv
module dtx_bus_sense
  import dtx_host_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic         strobe_a,
  input  logic         strobe_b,
  input  logic         reg_sel,
  input  logic [W-1:0] dq_in,
  output logic         wr_commit,
  output logic         wr_rs,
  output logic [W-1:0] wr_data,
  output logic         rd_active,
  output logic         rd_start,
  output logic         rd_start_rs,
  output logic         rd_end,
  output logic         rd_end_rs
);
  logic         s_cs_n, p_cs_n, s_a, s_b, s_rs;
  logic [W-1:0] s_d;
  bus_kind_e    kind_q, kind;
  logic         cs_fall, rd_now, wr_now, rd_q, wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_cs_n <= 1'b1;
      p_cs_n <= 1'b1;
      s_a    <= 1'b0;
      s_b    <= 1'b1;
      s_rs   <= 1'b0;
      s_d    <= '0;
    end else begin
      s_cs_n <= cs_n;
      p_cs_n <= s_cs_n;
      s_a    <= strobe_a;
      s_b    <= strobe_b;
      s_rs   <= reg_sel;
      s_d    <= dq_in;
    end
  end

  assign cs_fall = p_cs_n & ~s_cs_n;
  assign kind    = cs_fall ? bus_kind_e'(s_a) : kind_q;

  always_comb begin
    if (kind == BUS_SPLIT) begin
      rd_now = ~s_cs_n & ~s_a;
      wr_now = ~s_cs_n & ~s_b;
    end else begin
      rd_now = ~s_cs_n & s_a & s_b;
      wr_now = ~s_cs_n & s_a & ~s_b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q    <= BUS_SPLIT_NO;
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      wr_rs     <= 1'b0;
      wr_data   <= '0;
      rd_end_rs <= 1'b0;
    end else begin
      kind_q <= kind;
      rd_q   <= rd_now;
      wr_q   <= wr_now;
      if (wr_now) begin
        wr_data <= s_d;
        wr_rs   <= s_rs;
      end
      if (rd_now && !rd_q) rd_end_rs <= s_rs;
    end
  end

  assign wr_commit   = wr_q & ~wr_now;
  assign rd_active   = rd_now;
  assign rd_start    = rd_now & ~rd_q;
  assign rd_start_rs = s_rs;
  assign rd_end      = rd_q & ~rd_now;

  // R5
  rdwr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    rd_start |-> !wr_q);
endmodule

// File: rtl/dtx_ctrl_regs.sv
module dtx_ctrl_regs
  import dtx_host_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_commit,
  input  logic         wr_rs,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] ctrl_a,
  output logic [W-1:0] ctrl_b,
  output logic [W-1:0] tx_data,
  output logic         tx_load
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_a  <= '0;
      ctrl_b  <= '0;
      tx_data <= '0;
      tx_load <= 1'b0;
    end else begin
      tx_load <= 1'b0;
      if (wr_commit) begin
        if (!wr_rs) begin
          tx_data <= wr_data;
          tx_load <= 1'b1;
        end else if (ctrl_a[CA_REDIR]) begin
          ctrl_b           <= wr_data;
          ctrl_a[CA_REDIR] <= 1'b0;
        end else begin
          ctrl_a <= wr_data;
        end
      end
    end
  end

  // R3
  redirect_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && wr_rs && ctrl_a[CA_REDIR]) |=>
      (!ctrl_a[CA_REDIR] && ctrl_b == $past(wr_data)));
  // R4
  txpulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> !tx_load);
endmodule

// File: rtl/dtx_status_unit.sv
module dtx_status_unit
  import dtx_host_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cp_mode,
  input  logic         irq_en,
  input  logic         burst_on,
  input  logic         test_on,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_code,
  input  logic         dsteer,
  input  logic         tx_ready,
  input  logic         cp_cmp,
  input  logic         rd_start,
  input  logic         rd_end,
  input  logic         rd_end_rs,
  output logic [W-1:0] status,
  output logic [W-1:0] rx_reg,
  output logic         irq_pull
);
  logic [ST_EVT-1:0] snap, clr;
  logic              rx_set, tx_set;

  assign rx_set = rx_valid & ~cp_mode;
  assign tx_set = tx_ready & burst_on;

  for (genvar i = 0; i < ST_EVT; i++) begin : g_clr
    assign clr[i] = rd_end & rd_end_rs & snap[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status   <= '0;
      rx_reg   <= '0;
      snap     <= '0;
      irq_pull <= 1'b0;
    end else begin
      if (rd_start) snap <= status[ST_EVT-1:0];
      status[ST_DSTR] <= dsteer;
      if (rx_set)           status[ST_RXF] <= 1'b1;
      else if (clr[ST_RXF]) status[ST_RXF] <= 1'b0;
      if (!burst_on)        status[ST_TXE] <= 1'b0;
      else if (tx_set)      status[ST_TXE] <= 1'b1;
      else if (clr[ST_TXE]) status[ST_TXE] <= 1'b0;
      if (irq_en && (rx_set || tx_set)) status[ST_IRQ] <= 1'b1;
      else if (clr[ST_IRQ])             status[ST_IRQ] <= 1'b0;
      if (rx_set) rx_reg <= rx_code;
      if (cp_mode && irq_en)  irq_pull <= ~cp_cmp;
      else if (!cp_mode && test_on) irq_pull <= ~status[ST_DSTR];
      else if (!cp_mode && irq_en)  irq_pull <= status[ST_IRQ];
      else                          irq_pull <= 1'b0;
    end
  end

  // R7
  txe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !burst_on |=> !status[ST_TXE]);
  // R8
  irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status[ST_IRQ]) |-> $past(irq_en));
  // R9
  readclr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr[ST_RXF] && !rx_set) |=> !status[ST_RXF]);
  // R11
  cp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_mode && irq_en) |=> (irq_pull == !$past(cp_cmp)));
endmodule

// File: rtl/dtx_host_port.sv
module dtx_host_port
  import dtx_host_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic         strobe_a,
  input  logic         strobe_b,
  input  logic         reg_sel,
  input  logic [W-1:0] dq_in,
  output logic [W-1:0] dq_out,
  output logic         dq_oe,
  input  logic [W-1:0] rx_code,
  input  logic         rx_valid,
  input  logic         dsteer,
  input  logic         tx_ready,
  input  logic         cp_cmp,
  output logic [W-1:0] ctrl_a,
  output logic [W-1:0] ctrl_b,
  output logic [W-1:0] tx_data,
  output logic         tx_load,
  output logic         irq_pull
);
  logic         wr_commit, wr_rs, rd_active, rd_start, rd_start_rs;
  logic         rd_end, rd_end_rs;
  logic [W-1:0] wr_data, status, rx_reg;

  dtx_bus_sense #(.W(W)) u_sense (
    .clk(clk), .rst(rst), .cs_n(cs_n), .strobe_a(strobe_a),
    .strobe_b(strobe_b), .reg_sel(reg_sel), .dq_in(dq_in),
    .wr_commit(wr_commit), .wr_rs(wr_rs), .wr_data(wr_data),
    .rd_active(rd_active), .rd_start(rd_start), .rd_start_rs(rd_start_rs),
    .rd_end(rd_end), .rd_end_rs(rd_end_rs)
  );

  dtx_ctrl_regs #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_commit(wr_commit), .wr_rs(wr_rs),
    .wr_data(wr_data), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b),
    .tx_data(tx_data), .tx_load(tx_load)
  );

  dtx_status_unit #(.W(W)) u_stat (
    .clk(clk), .rst(rst), .cp_mode(ctrl_a[CA_CP]), .irq_en(ctrl_a[CA_IRQ]),
    .burst_on(~ctrl_b[CB_NOBURST]), .test_on(ctrl_b[CB_TEST]),
    .rx_valid(rx_valid), .rx_code(rx_code), .dsteer(dsteer),
    .tx_ready(tx_ready), .cp_cmp(cp_cmp), .rd_start(rd_start),
    .rd_end(rd_end), .rd_end_rs(rd_end_rs), .status(status),
    .rx_reg(rx_reg), .irq_pull(irq_pull)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      dq_oe <= rd_active;
      if (rd_start) dq_out <= rd_start_rs ? status : rx_reg;
    end
  end

  // R5
  hiz_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n, 2) |-> !dq_oe);
endmodule

// File: tb/tb_dtx_host_port.sv
`timescale 1ns/1ps
module tb_dtx_host_port;
  logic       clk = 0, rst = 1;
  logic       cs_n = 1, strobe_a = 0, strobe_b = 1, reg_sel = 0;
  logic [3:0] dq_in = 0, rx_code = 0;
  logic       rx_valid = 0, dsteer = 0, tx_ready = 0, cp_cmp = 0;
  logic [3:0] dq_out, ctrl_a, ctrl_b, tx_data;
  logic       dq_oe, tx_load, irq_pull;
  int checks = 0, errors = 0, loads = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dtx_host_port dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .strobe_a(strobe_a),
    .strobe_b(strobe_b), .reg_sel(reg_sel), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .rx_code(rx_code),
    .rx_valid(rx_valid), .dsteer(dsteer), .tx_ready(tx_ready),
    .cp_cmp(cp_cmp), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b),
    .tx_data(tx_data), .tx_load(tx_load), .irq_pull(irq_pull)
  );

  always @(posedge clk) if (tx_load) loads++;

  // {split, rs, write, data/expected read, exp ctrl_a, exp ctrl_b}
  localparam logic [14:0] VEC [8] = '{
    15'b0_1_1_1000_1000_0000,
    15'b1_1_1_0110_0000_0110,
    15'b0_1_1_0101_0101_0110,
    15'b1_1_1_1101_1101_0110,
    15'b1_1_1_0001_0101_0001,
    15'b0_1_1_0011_0011_0001,
    15'b1_1_0_0000_0011_0001,
    15'b0_0_1_0111_0011_0001
  };

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input bit split, input bit rsv, input logic [3:0] d);
    reg_sel = rsv; dq_in = d;
    strobe_a = split; strobe_b = 1;
    idle(2); cs_n = 0; idle(3);
    if (split) strobe_b = 0;
    else begin strobe_b = 0; idle(1); strobe_a = 1; end
    idle(3);
    chk("R5 no drive during write", dq_oe, 0);
    if (split) strobe_b = 1; else strobe_a = 0;
    idle(3); cs_n = 1; strobe_b = 1; idle(3);
  endtask

  task automatic bus_rd(input bit split, input bit rsv, input bit mid_rx,
                        input logic [3:0] mid_code, output logic [3:0] d);
    reg_sel = rsv; strobe_a = split; strobe_b = 1;
    idle(2); cs_n = 0; idle(3);
    chk("R1 idle strobes after select", dq_oe, 0);
    strobe_a = !split; idle(4);
    chk("R5 drive during read", dq_oe, 1);
    d = dq_out;
    if (mid_rx) begin
      rx_code = mid_code; rx_valid = 1; idle(1); rx_valid = 0;
    end
    idle(1);
    strobe_a = split; idle(3); cs_n = 1; idle(3);
  endtask

  task automatic pulse_rx(input logic [3:0] c);
    rx_code = c; rx_valid = 1; idle(1); rx_valid = 0; idle(3);
  endtask

  task automatic pulse_tx();
    tx_ready = 1; idle(1); tx_ready = 0; idle(3);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] r;
    idle(3); rst = 0; idle(2);
    // R12 reset state
    chk("R12 ctrl_a", ctrl_a, 0);
    chk("R12 ctrl_b", ctrl_b, 0);
    chk("R12 dq_oe", dq_oe, 0);
    chk("R12 irq_pull", irq_pull, 0);

    // R1 R2 R3 table walk in both protocols
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][12]) bus_wr(VEC[i][14], VEC[i][13], VEC[i][11:8]);
      else begin
        bus_rd(VEC[i][14], VEC[i][13], 0, 0, r);
        chk("R2 table read", r, VEC[i][11:8]);
      end
      chk("R3 table ctrl_a", ctrl_a, VEC[i][7:4]);
      chk("R3 table ctrl_b", ctrl_b, VEC[i][3:0]);
    end
    // R4 transmit write
    chk("R4 tx_data", tx_data, 4'h7);
    chk("R4 tx_load count", loads, 1);

    // R10 R6 R8 digit with interrupt enabled, DTMF
    bus_wr(1, 1, 4'b0100);
    pulse_rx(4'h9);
    chk("R10 irq low on digit", irq_pull, 1);
    bus_rd(0, 1, 0, 0, r);
    chk("R6 R8 status after digit", r, 4'b0101);
    chk("R10 irq released", irq_pull, 0);
    bus_rd(0, 1, 0, 0, r);
    chk("R9 status cleared", r, 4'b0000);
    bus_rd(1, 0, 0, 0, r);
    chk("R2 R6 rx code", r, 4'h9);

    // R9 flag set during a status read survives
    bus_rd(1, 1, 1, 4'h4, r);
    chk("R9 read value before event", r, 4'b0000);
    bus_rd(0, 1, 0, 0, r);
    chk("R9 flag kept", r, 4'b0101);
    bus_rd(0, 0, 0, 0, r);
    chk("R6 rx code 2", r, 4'h4);

    // R7 burst mode transmit-empty
    bus_wr(0, 1, 4'b1100);
    bus_wr(0, 1, 4'b0000);
    chk("R3 ctrl_a after redirect", ctrl_a, 4'b0100);
    pulse_tx();
    bus_rd(1, 1, 0, 0, r);
    chk("R7 R8 tx empty", r, 4'b0011);
    pulse_tx();
    bus_wr(1, 1, 4'b1100);
    bus_wr(1, 1, 4'b0001);
    bus_rd(1, 1, 0, 0, r);
    chk("R7 forced clear off burst", r, 4'b0001);
    pulse_tx();
    bus_rd(0, 1, 0, 0, r);
    chk("R7 ignored off burst", r, 4'b0000);

    // R8 R10 interrupts disabled
    bus_wr(0, 1, 4'b0000);
    pulse_rx(4'h2);
    chk("R10 no irq when disabled", irq_pull, 0);
    bus_rd(1, 1, 0, 0, r);
    chk("R8 no irq flag", r, 4'b0100);

    // R11 R6 call-progress mode
    bus_wr(1, 1, 4'b0110);
    cp_cmp = 1; idle(3);
    chk("R11 cp high", irq_pull, 0);
    cp_cmp = 0; idle(3);
    chk("R11 cp low", irq_pull, 1);
    pulse_rx(4'hE);
    bus_rd(0, 1, 0, 0, r);
    chk("R6 no receive in cp", r, 4'b0000);
    bus_rd(0, 0, 0, 0, r);
    chk("R6 rx code kept in cp", r, 4'h2);

    // R11 R6 test mode mirrors delayed steering
    bus_wr(0, 1, 4'b1000);
    bus_wr(0, 1, 4'b0011);
    dsteer = 1; idle(4);
    chk("R11 test dsteer high", irq_pull, 0);
    bus_rd(1, 1, 0, 0, r);
    chk("R6 dsteer bit", r, 4'b1000);
    dsteer = 0; idle(4);
    chk("R11 test dsteer low", irq_pull, 1);

    // R12 reset clears redirect
    bus_wr(1, 1, 4'b1100);
    pulse_rx(4'h3);
    rst = 1; idle(2); rst = 0; idle(2);
    chk("R12 ctrl_a cleared", ctrl_a, 0);
    chk("R12 ctrl_b cleared", ctrl_b, 0);
    bus_wr(0, 1, 4'b0101);
    chk("R12 R3 redirect dropped a", ctrl_a, 4'b0101);
    chk("R12 R3 redirect dropped b", ctrl_b, 4'b0000);
    bus_rd(0, 1, 0, 0, r);
    chk("R12 status cleared", r, 4'b0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule